// File: doc/BRIEF.md
# Serial Channel-Word Receiver

This block sits between a three-wire serial host port (active-low select, serial clock, serial data) and the channel memory of a multi-channel output sequencer. It collects 24-bit command words and turns each finished word into a single write of a 12-bit code into one of 32 channel locations. It also latches the two mode bits carried in that word. The serial lines are expected to be synchronised to the block clock upstream. The block finds serial-clock rising edges by comparing each clock's value with the value held from the previous clock.

One select frame can hold any number of back-to-back words, and every 24th bit commits its own write. Bits left over when select rises are thrown away. The latched mode bits are ORed with two level pins, so that either source can force immediate-update mode or external sequencer clocking. While the sequencer runs its reset pass, the serial port is deaf. A registered busy flag tells the sequencer that a frame is in progress.

Top module: `chan_word_rx`

## Requirements
- R1: After reset, wr_en is 0, busy is 0, and both latched mode bits are 0, so mode_immed and mode_extclk simply follow their pins.
- R2: While cs_n is low and seq_reset is low, each rising edge of sclk shifts in sdi. The first such edge after cs_n falls carries bit 23 (the MSB). wr_en pulses high for exactly one clock, starting the clock after the edge that carries bit 0.
- R3: On a write, wr_data holds word bits 23..12 and wr_addr holds word bits 7..3. Address value n selects channel n.
- R4: A frame carrying k whole words produces k writes, in the order the words were sent.
- R5: When cs_n rises with fewer than 24 bits collected, those bits produce no write. The next frame starts again at bit 23.
- R6: Word bit 2 (1 means immediate update) is latched at each write. mode_immed is that latched bit ORed with immed_pin.
- R7: Word bit 1 (1 means external clock) is latched at each write, so a later word with the bit at 0 clears it. mode_extclk is that latched bit ORed with extclk_pin.
- R8: While seq_reset is high, serial input is ignored: there are no writes, the partial word is cleared, and busy is 0.
- R9: Spacer bits 11..8 and fill bit 0 do not affect wr_data, wr_addr or the mode outputs.
- R10: busy equals the previous clock's value of (cs_n low and seq_reset low).
- R11: sclk edges while cs_n is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_reset | input | 1 | Sequencer reset pass in progress; serial input ignored |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock (synchronised) |
| sdi | input | 1 | Serial data, sampled on sclk rise |
| immed_pin | input | 1 | External force for immediate-update mode |
| extclk_pin | input | 1 | External force for external sequencer clock |
| wr_en | output | 1 | One-clock channel memory write strobe |
| wr_addr | output | 5 | Channel address of the write |
| wr_data | output | 12 | Channel code of the write |
| mode_immed | output | 1 | Effective immediate-update mode |
| mode_extclk | output | 1 | Effective external-clock mode |
| busy | output | 1 | Frame in progress, for the sequencer |

## Verification
The bench builds the block with its default widths: 12 data bits, 5 address bits and 4 spacer bits, which makes a 24-bit word. With these values, one 32-word frame reaches every channel address once. The bench also loads non-zero spacer and fill bits into half of those words. Frames of one, three and thirty-two words are sent, along with a truncated frame and stray clocks outside a frame. This exercises the bit-counter wrap and the discard path at the real word length.

// File: rtl/chan_word_rx.sv
module chan_word_rx #(
  parameter int DATA_W   = 12,
  parameter int ADDR_W   = 5,
  parameter int SPACER_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_reset,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              immed_pin,
  input  logic              extclk_pin,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              mode_immed,
  output logic              mode_extclk,
  output logic              busy
);

  localparam int WORD_W   = DATA_W + SPACER_W + ADDR_W + 3;
  localparam int CNT_W    = $clog2(WORD_W + 1);
  localparam int ADDR_LSB = 3;
  localparam int SPC_LSB  = ADDR_LSB + ADDR_W;

  logic              sclk_q;
  logic [WORD_W-2:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              c1_q, c0_q;

  wire              take = sclk & ~sclk_q & ~cs_n & ~seq_reset;
  wire [WORD_W-1:0] nxt  = {shreg, sdi};
  wire              last = (cnt == CNT_W'(WORD_W - 1));

  logic unused_bits;
  assign unused_bits = ^{nxt[SPC_LSB +: SPACER_W], nxt[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      shreg   <= '0;
      cnt     <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      c1_q    <= 1'b0;
      c0_q    <= 1'b0;
      busy    <= 1'b0;
    end else begin
      sclk_q <= sclk;
      busy   <= ~cs_n & ~seq_reset;
      wr_en  <= 1'b0;
      if (cs_n || seq_reset) begin
        cnt <= '0;
      end else if (take) begin
        shreg <= nxt[WORD_W-2:0];
        if (last) begin
          cnt     <= '0;
          wr_en   <= 1'b1;
          wr_data <= nxt[WORD_W-1 -: DATA_W];
          wr_addr <= nxt[ADDR_LSB +: ADDR_W];
          c1_q    <= nxt[2];
          c0_q    <= nxt[1];
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign mode_immed  = c1_q | immed_pin;
  assign mode_extclk = c0_q | extclk_pin;

  // R2
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R8
  seq_reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_reset |=> (!wr_en && !busy && cnt == '0));

  // R5
  partial_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (cnt == '0 && !wr_en));

  // R10
  busy_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !seq_reset) |=> busy);

  // R7
  mode_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({c1_q, c0_q}) |-> wr_en);

  // R11
  idle_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(shreg));

endmodule

// File: tb/chan_word_rx_bench.sv
module chan_word_rx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seq_reset = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic immed_pin = 1'b0, extclk_pin = 1'b0;
  logic wr_en, mode_immed, mode_extclk, busy;
  logic [4:0] wr_addr;
  logic [11:0] wr_data;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  chan_word_rx u_chan_word_rx (
    .clk(clk), .rst_n(rst_n), .seq_reset(seq_reset), .cs_n(cs_n), .sclk(sclk),
    .sdi(sdi), .immed_pin(immed_pin), .extclk_pin(extclk_pin), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .mode_immed(mode_immed),
    .mode_extclk(mode_extclk), .busy(busy));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_cnt = 0, m_word = 0;
  bit m_prev = 0, e_we = 0, e_c1 = 0, e_c0 = 0, e_busy = 0;
  int e_addr = 0, e_data = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_word = 0; m_prev = 0; e_we = 0; e_c1 = 0; e_c0 = 0; e_busy = 0;
    end else begin
      e_busy = !cs_n && !seq_reset;
      e_we = 0;
      if (seq_reset || cs_n) m_cnt = 0;
      else if (sclk && !m_prev) begin
        m_word = ((m_word << 1) | int'(sdi)) & 32'hFFFFFF;
        m_cnt++;
        if (m_cnt == 24) begin
          m_cnt = 0; e_we = 1;
          e_data = (m_word >> 12) & 12'hFFF;
          e_addr = (m_word >> 3) & 5'h1F;
          e_c1 = m_word[2]; e_c0 = m_word[1];
        end
      end
      m_prev = sclk;
    end
  end

  int got[$];
  always @(negedge clk) if (rst_n && !done) begin
    chk(wr_en == e_we, "R2 wr_en", wr_en, e_we);
    if (e_we) begin
      chk(wr_data == e_data[11:0], "R3 wr_data", wr_data, e_data);
      chk(wr_addr == e_addr[4:0], "R3 wr_addr", wr_addr, e_addr);
      got.push_back({wr_addr, wr_data});
    end
    chk(mode_immed == (e_c1 | immed_pin), "R6 mode_immed", mode_immed, e_c1 | immed_pin);
    chk(mode_extclk == (e_c0 | extclk_pin), "R7 mode_extclk", mode_extclk, e_c0 | extclk_pin);
    chk(busy == e_busy, "R10 busy", busy, e_busy);
  end

  int expq[$];

  function automatic logic [23:0] mk(int d, int a, bit c1, bit c0, int spc, bit fill);
    return {d[11:0], spc[3:0], a[4:0], c1, c0, fill};
  endfunction

  task automatic send_bit(input bit b);
    @(negedge clk); sdi = b; sclk = 1'b0;
    @(negedge clk);
    @(negedge clk); sclk = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_word(input logic [23:0] w, input bit counted);
    for (int i = 23; i >= 0; i--) send_bit(w[i]);
    if (counted) expq.push_back({w[7:3], w[23:12]});
  endtask

  task automatic open_frame();
    @(negedge clk); cs_n = 1'b0; sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic close_frame();
    @(negedge clk); sclk = 1'b0;
    repeat (2) @(negedge clk); cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic cmp_writes(input string tag);
    chk(got.size() == expq.size(), tag, got.size(), expq.size());
    for (int i = 0; i < expq.size() && i < got.size(); i++)
      chk(got[i] == expq[i], tag, got[i], expq[i]);
    got.delete(); expq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(wr_en == 0 && busy == 0, "R1 reset outputs", {wr_en, busy}, 0);
    chk(mode_immed == 0 && mode_extclk == 0, "R1 reset modes", {mode_immed, mode_extclk}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 single-word frame
    open_frame(); send_word(mk(12'hA5C, 20, 1, 0, 0, 0), 1); close_frame();
    cmp_writes("R2 single word");
    chk(mode_immed == 1, "R6 latched immediate", mode_immed, 1);

    // R4 R7 three words, C0 set then cleared
    open_frame();
    send_word(mk(12'h001, 0, 0, 0, 0, 0), 1);
    send_word(mk(12'hFFF, 31, 0, 1, 0, 0), 1);
    chk(mode_extclk == 1, "R7 extclk latched", mode_extclk, 1);
    send_word(mk(12'h800, 7, 0, 0, 0, 0), 1);
    close_frame();
    cmp_writes("R4 three words");
    chk(mode_extclk == 0, "R7 extclk must repeat", mode_extclk, 0);

    // R6 R7 pins OR with latched bits
    immed_pin = 1; extclk_pin = 1;
    @(negedge clk);
    chk(mode_immed == 1 && mode_extclk == 1, "R6 pins force modes", {mode_immed, mode_extclk}, 3);
    immed_pin = 0; extclk_pin = 0;

    // R4 R9 32-word frame covering every address, junk spacer and fill on odd words
    open_frame();
    for (int i = 0; i < 32; i++)
      send_word(mk(i * 129 + 3, i, i[0], i[1], (i & 1) ? 4'hF : 0, i[0]), 1);
    close_frame();
    cmp_writes("R9 32 words");

    // R5 truncated frame then a fresh word
    open_frame();
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    close_frame();
    cmp_writes("R5 truncated no write");
    open_frame(); send_word(mk(12'h3C3, 9, 0, 0, 0, 0), 1); close_frame();
    cmp_writes("R5 fresh word after truncation");

    // R11 stray clocks outside a frame
    for (int i = 0; i < 30; i++) send_bit(i[0]);
    cmp_writes("R11 idle clocks ignored");

    // R8 serial ignored during sequencer reset pass
    @(negedge clk); seq_reset = 1'b1;
    open_frame(); send_word(mk(12'h777, 5, 1, 1, 0, 0), 0); close_frame();
    chk(busy == 0, "R8 busy low in reset pass", busy, 0);
    seq_reset = 1'b0;
    cmp_writes("R8 no write in reset pass");
    chk(mode_immed == 0 && mode_extclk == 0, "R8 modes untouched", {mode_immed, mode_extclk}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule